// File: doc/BRIEF.md
# Depthwise Three-Tap Vector Convolution Unit

This unit performs one step of a depthwise convolution across 32 byte lanes. Each command selects three data vectors (previous, current, next) out of nine supplied 32-byte data vectors and pairs them with three 32-byte filter vectors. For every lane it forms three tap products of biased data and biased filter bytes, sums them, and adds the sum into a 32-entry, 32-bit accumulator held inside the unit.

Vector inputs arrive in an interleaved byte order: the logical lane with group index g (lane / 8) and position p (lane mod 8) sits at physical byte 4·p + m(g), where m maps 0→0, 1→2, 2→1, 3→3. The accumulator and destination outputs are in plain logical order. A sparsity field chooses how the three taps are drawn from the selected vectors. One mode shifts taps within 8-lane groups and takes fill-in from neighbouring vectors. Another reads three consecutive positions of one vector. An optional write-out copies the updated accumulator into a four-register destination image. An unsupported sparsity code is reported and leaves all state alone.

Top module: `dwconv_unit`

## Requirements
- R1: While rst_ni is low and after its release, the accumulator and destination outputs read zero and done_o and illegal_o are low; done_o and illegal_o stay low in any cycle that follows a cycle without cmd_valid_i.
- R2: Logical lane i of every data and filter input vector is read from physical byte 4·(i mod 8) + m(i/8), with m(0)=0, m(1)=2, m(2)=1, m(3)=3; acc_o bits [32i+31:32i] hold logical lane i.
- R3: Each lane adds the sum over taps k=0..2 of (d_k + bias_d)·(f_k + bias_f), modulo 2^32. Filter tap k is lane i of filter vector k (filt_i bits [256k+255:256k]). Data bytes are sign-extended when cmd bit 6 is 1, and filter bytes when cmd bit 15 is 1; otherwise both are zero-extended. The biases bias_d = cmd[14:7] and bias_f = cmd[23:16] are signed 8-bit values.
- R4: For base selector cmd[5:2] = b in 0..6, the previous, current and next vectors are data vectors b, b+1 and b+2, where data vector n occupies data_i bits [256n+255:256n].
- R5: For b = 7..15, (previous, current, next) is 7→(1,0,2), 8→(1,2,0), 9→(3,4,0), 10→(5,6,0), 11→(7,8,0), 12→(2,0,1), 13→(4,0,1), 14→(6,0,1), 15→(8,0,1).
- R6: With sparsity cmd[1:0]=0, taps 0, 1 and 2 are lane i of the previous, current and next vectors.
- R7: With sparsity 1, for lane i in group j at position p, taps 0..2 are current-vector positions p−1, p, p+1 of group j. Position −1 is replaced by previous-vector lane 8j+7, and position 8 by next-vector lane 8j.
- R8: With sparsity 2, taps 0..2 are previous-vector positions p, p+1, p+2 of group j. A position q > 7 is replaced by current-vector lane 8j+q−8.
- R9: A command with sparsity 3 pulses illegal_o in the following cycle and changes neither acc_o nor dst_o; done_o stays low.
- R10: dst_o changes only after a legal command issued with wr_en_i high. It then equals the updated accumulator, destination register r element e at dst_o bits [32(8r+e)+31:32(8r+e)] holding lane 8r+e.
- R11: A legal command adds its lane sums to the accumulator. clr_i alone zeroes the accumulator. clr_i together with a legal command loads just that command's sums.
- R12: done_o is high for exactly the cycle after each legal command is accepted, back-to-back commands giving consecutive pulses.
- R13: Command bits [31:24] have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous accumulator clear |
| cmd_valid_i | input | 1 | Command accepted this cycle |
| cmd_i | input | 32 | Command word |
| wr_en_i | input | 1 | Copy updated accumulator to destination image |
| data_i | input | 2304 | Nine swizzled 32-byte data vectors |
| filt_i | input | 768 | Three swizzled 32-byte filter vectors |
| done_o | output | 1 | Legal command completed |
| illegal_o | output | 1 | Unsupported command rejected |
| acc_o | output | 1024 | Accumulator, 32 lanes of 32 bits |
| dst_o | output | 1024 | Destination image, four registers of eight words |

## Verification
The clear input and a legal command can land in the same cycle. The expected result is that command's sums alone, with the old accumulator contents gone, and any write-out must carry that same value. The bench builds up a non-zero accumulator over several commands and then raises clear alongside a command, with write-out both on and off. It also raises clear alongside an illegal command, where the clear must still happen while the destination image holds. Every cycle, a behavioural model that replays the lane arithmetic with integers judges the accumulator, the destination image and both pulses.

// File: rtl/dwc_pkg.sv
package dwc_pkg;

  typedef enum logic [1:0] {
    SPARSE_DIRECT = 2'd0,
    SPARSE_CENTER = 2'd1,
    SPARSE_STRIDE = 2'd2,
    SPARSE_BAD    = 2'd3
  } sparse_e;

  // Field order fixed by the command encoding (MSB first).
  typedef struct packed {
    logic [7:0] fbias;
    logic       fsigned;
    logic [7:0] dbias;
    logic       dsigned;
    logic [3:0] base;
    sparse_e    sparse;
  } cmd_t;

  localparam int unsigned CMD_W = $bits(cmd_t);

  // Physical byte holding logical lane; four groups, middle two swapped.
  function automatic int unsigned phys_byte(int unsigned lane, int unsigned grp);
    int unsigned g, gm, p;
    p  = lane % grp;
    g  = (lane / grp) % 4;
    gm = ((g & 1) << 1) | ((g >> 1) & 1);
    return (p << 2) | gm;
  endfunction

endpackage

// File: rtl/dwc_reg_select.sv
module dwc_reg_select #(
  parameter int unsigned NREG = 9,
  parameter int unsigned VW   = 256
) (
  input  logic [NREG*VW-1:0] data_i,
  input  logic [3:0]         base_i,
  output logic [VW-1:0]      prev_o,
  output logic [VW-1:0]      curr_o,
  output logic [VW-1:0]      next_o
);
  localparam int unsigned IW = $clog2(NREG);

  logic [IW-1:0] p_idx, c_idx, n_idx;

  always_comb begin
    p_idx = IW'(base_i);
    c_idx = IW'(base_i) + IW'(1);
    n_idx = IW'(base_i) + IW'(2);
    unique case (base_i)
      4'd7:    begin p_idx = IW'(1); c_idx = IW'(0); n_idx = IW'(2); end
      4'd8:    begin p_idx = IW'(1); c_idx = IW'(2); n_idx = IW'(0); end
      4'd9:    begin p_idx = IW'(3); c_idx = IW'(4); n_idx = IW'(0); end
      4'd10:   begin p_idx = IW'(5); c_idx = IW'(6); n_idx = IW'(0); end
      4'd11:   begin p_idx = IW'(7); c_idx = IW'(8); n_idx = IW'(0); end
      4'd12:   begin p_idx = IW'(2); c_idx = IW'(0); n_idx = IW'(1); end
      4'd13:   begin p_idx = IW'(4); c_idx = IW'(0); n_idx = IW'(1); end
      4'd14:   begin p_idx = IW'(6); c_idx = IW'(0); n_idx = IW'(1); end
      4'd15:   begin p_idx = IW'(8); c_idx = IW'(0); n_idx = IW'(1); end
      default: ;
    endcase
  end

  assign prev_o = data_i[p_idx*VW +: VW];
  assign curr_o = data_i[c_idx*VW +: VW];
  assign next_o = data_i[n_idx*VW +: VW];

endmodule

// File: rtl/dwc_tap_shift.sv
module dwc_tap_shift
  import dwc_pkg::*;
#(
  parameter int unsigned LANES = 32,
  parameter int unsigned GROUP = 8,
  parameter int unsigned BW    = 8,
  parameter int unsigned NTAP  = 3
) (
  input  logic [LANES*BW-1:0]      prev_i,
  input  logic [LANES*BW-1:0]      curr_i,
  input  logic [LANES*BW-1:0]      next_i,
  input  logic [NTAP*LANES*BW-1:0] filt_i,
  input  sparse_e                  sparse_i,
  output logic [NTAP*LANES*BW-1:0] dtap_o,
  output logic [NTAP*LANES*BW-1:0] ftap_o
);
  localparam int unsigned VW = LANES*BW;

  logic [BW-1:0] pv [LANES];
  logic [BW-1:0] cv [LANES];
  logic [BW-1:0] nv [LANES];

  for (genvar i = 0; i < LANES; i++) begin : g_unswz
    localparam int unsigned PB = phys_byte(i, GROUP);
    assign pv[i] = prev_i[PB*BW +: BW];
    assign cv[i] = curr_i[PB*BW +: BW];
    assign nv[i] = next_i[PB*BW +: BW];
    for (genvar k = 0; k < NTAP; k++) begin : g_filt
      assign ftap_o[(k*LANES+i)*BW +: BW] = filt_i[k*VW + PB*BW +: BW];
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam int unsigned J = i / GROUP;
    localparam int unsigned P = i % GROUP;
    logic [BW-1:0] c_lo, c_hi, s_one, s_two;

    if (P == 0) begin : g_lo_edge
      assign c_lo = pv[J*GROUP + GROUP-1];
    end else begin : g_lo_in
      assign c_lo = cv[i-1];
    end

    if (P == GROUP-1) begin : g_hi_edge
      assign c_hi  = nv[J*GROUP];
      assign s_one = cv[J*GROUP];
    end else begin : g_hi_in
      assign c_hi  = cv[i+1];
      assign s_one = pv[i+1];
    end

    if (P >= GROUP-2) begin : g_two_edge
      assign s_two = cv[J*GROUP + P + 2 - GROUP];
    end else begin : g_two_in
      assign s_two = pv[i+2];
    end

    always_comb begin
      unique case (sparse_i)
        SPARSE_CENTER: begin
          dtap_o[(0*LANES+i)*BW +: BW] = c_lo;
          dtap_o[(1*LANES+i)*BW +: BW] = cv[i];
          dtap_o[(2*LANES+i)*BW +: BW] = c_hi;
        end
        SPARSE_STRIDE: begin
          dtap_o[(0*LANES+i)*BW +: BW] = pv[i];
          dtap_o[(1*LANES+i)*BW +: BW] = s_one;
          dtap_o[(2*LANES+i)*BW +: BW] = s_two;
        end
        default: begin
          dtap_o[(0*LANES+i)*BW +: BW] = pv[i];
          dtap_o[(1*LANES+i)*BW +: BW] = cv[i];
          dtap_o[(2*LANES+i)*BW +: BW] = nv[i];
        end
      endcase
    end
  end

endmodule

// File: rtl/dwc_lane_mac.sv
module dwc_lane_mac #(
  parameter int unsigned BW   = 8,
  parameter int unsigned AW   = 32,
  parameter int unsigned NTAP = 3
) (
  input  logic [NTAP*BW-1:0] d_i,
  input  logic [NTAP*BW-1:0] f_i,
  input  logic               dsigned_i,
  input  logic               fsigned_i,
  input  logic [BW-1:0]      dbias_i,
  input  logic [BW-1:0]      fbias_i,
  output logic [AW-1:0]      sum_o
);
  localparam int unsigned XW = AW - BW;

  logic [AW-1:0] db_x, fb_x;
  assign db_x = {{XW{dbias_i[BW-1]}}, dbias_i};
  assign fb_x = {{XW{fbias_i[BW-1]}}, fbias_i};

  always_comb begin
    logic [AW-1:0] dv, fv;
    sum_o = '0;
    for (int k = 0; k < NTAP; k++) begin
      dv = {{XW{dsigned_i & d_i[k*BW+BW-1]}}, d_i[k*BW +: BW]} + db_x;
      fv = {{XW{fsigned_i & f_i[k*BW+BW-1]}}, f_i[k*BW +: BW]} + fb_x;
      sum_o = sum_o + dv * fv;
    end
  end

endmodule

// File: rtl/dwconv_unit.sv
module dwconv_unit
  import dwc_pkg::*;
#(
  parameter int unsigned LANES = 32,
  parameter int unsigned GROUP = 8,
  parameter int unsigned BW    = 8,
  parameter int unsigned AW    = 32,
  parameter int unsigned NREG  = 9,
  parameter int unsigned NTAP  = 3,
  parameter int unsigned CW    = 32
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   clr_i,
  input  logic                   cmd_valid_i,
  input  logic [CW-1:0]          cmd_i,
  input  logic                   wr_en_i,
  input  logic [NREG*LANES*BW-1:0] data_i,
  input  logic [NTAP*LANES*BW-1:0] filt_i,
  output logic                   done_o,
  output logic                   illegal_o,
  output logic [LANES*AW-1:0]    acc_o,
  output logic [LANES*AW-1:0]    dst_o
);
  localparam int unsigned VW = LANES*BW;

  cmd_t cmd;
  assign cmd = cmd_t'(cmd_i[CMD_W-1:0]);

  logic unused_cmd_hi;
  assign unused_cmd_hi = ^cmd_i[CW-1:CMD_W];

  logic legal, go;
  assign legal = (cmd.sparse != SPARSE_BAD);
  assign go    = cmd_valid_i & legal;

  logic [VW-1:0] prev_v, curr_v, next_v;
  logic [NTAP*VW-1:0] dtap, ftap;

  dwc_reg_select #(.NREG(NREG), .VW(VW)) u_sel (
    .data_i (data_i),
    .base_i (cmd.base),
    .prev_o (prev_v),
    .curr_o (curr_v),
    .next_o (next_v)
  );

  dwc_tap_shift #(.LANES(LANES), .GROUP(GROUP), .BW(BW), .NTAP(NTAP)) u_shift (
    .prev_i   (prev_v),
    .curr_i   (curr_v),
    .next_i   (next_v),
    .filt_i   (filt_i),
    .sparse_i (cmd.sparse),
    .dtap_o   (dtap),
    .ftap_o   (ftap)
  );

  logic [AW-1:0] acc_q [LANES];
  logic [AW-1:0] dst_q [LANES];
  logic [AW-1:0] nxt   [LANES];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [NTAP*BW-1:0] d_l, f_l;
    logic [AW-1:0]      sum_l;
    for (genvar k = 0; k < NTAP; k++) begin : g_tap
      assign d_l[k*BW +: BW] = dtap[(k*LANES+i)*BW +: BW];
      assign f_l[k*BW +: BW] = ftap[(k*LANES+i)*BW +: BW];
    end

    dwc_lane_mac #(.BW(BW), .AW(AW), .NTAP(NTAP)) u_mac (
      .d_i       (d_l),
      .f_i       (f_l),
      .dsigned_i (cmd.dsigned),
      .fsigned_i (cmd.fsigned),
      .dbias_i   (cmd.dbias),
      .fbias_i   (cmd.fbias),
      .sum_o     (sum_l)
    );

    // clear-with-command loads the new sums only
    assign nxt[i] = (clr_i ? '0 : acc_q[i]) + sum_l;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        acc_q[i] <= '0;
        dst_q[i] <= '0;
      end else begin
        if (go)         acc_q[i] <= nxt[i];
        else if (clr_i) acc_q[i] <= '0;
        if (go && wr_en_i) dst_q[i] <= nxt[i];
      end
    end

    // lane 8r+e is destination register r element e
    assign acc_o[i*AW +: AW] = acc_q[i];
    assign dst_o[i*AW +: AW] = dst_q[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o    <= 1'b0;
      illegal_o <= 1'b0;
    end else begin
      done_o    <= go;
      illegal_o <= cmd_valid_i & ~legal;
    end
  end

endmodule

// File: rtl/dwconv_unit_chk.sv
module dwconv_unit_chk #(
  parameter int unsigned LANES = 32,
  parameter int unsigned AW    = 32
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                clr_i,
  input logic                cmd_valid_i,
  input logic [1:0]          sparse_i,
  input logic                wr_en_i,
  input logic                done_o,
  input logic                illegal_o,
  input logic [LANES*AW-1:0] acc_o,
  input logic [LANES*AW-1:0] dst_o
);

  assert_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_i |=> (!done_o && !illegal_o));

  assert_done_pulse_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && sparse_i != 2'd3) |=> (done_o && !illegal_o));

  assert_illegal_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && sparse_i == 2'd3 && !clr_i) |=>
      (illegal_o && !done_o && acc_o == $past(acc_o) && dst_o == $past(dst_o)));

  assert_clear_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !(cmd_valid_i && sparse_i != 2'd3)) |=> (acc_o == '0));

  assert_dst_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd_valid_i && wr_en_i) |=> $stable(dst_o));

  assert_dst_copy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && wr_en_i && sparse_i != 2'd3) |=> (dst_o == acc_o));

endmodule

bind dwconv_unit dwconv_unit_chk #(.LANES(LANES), .AW(AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .clr_i       (clr_i),
  .cmd_valid_i (cmd_valid_i),
  .sparse_i    (cmd_i[1:0]),
  .wr_en_i     (wr_en_i),
  .done_o      (done_o),
  .illegal_o   (illegal_o),
  .acc_o       (acc_o),
  .dst_o       (dst_o)
);

// File: tb/dwconv_unit_bench.sv
`timescale 1ns/1ps
module dwconv_unit_bench;
  localparam int NL = 32;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic clr_i = 1'b0;
  logic cmd_valid_i = 1'b0;
  logic [31:0] cmd_i = '0;
  logic wr_en_i = 1'b0;
  logic [9*256-1:0] data_i;
  logic [3*256-1:0] filt_i;
  logic done_o, illegal_o;
  logic [NL*32-1:0] acc_o, dst_o;

  logic [7:0] dat [9][NL];
  logic [7:0] fil [3][NL];

  int compared = 0;
  int mismatched = 0;
  bit running = 1'b0;
  string cur_tag = "R1";
  string m_tag = "R1";

  logic [31:0] macc [NL];
  logic [31:0] mdst [NL];
  bit mdone, mill;

  always #2 clk = ~clk;

  dwconv_unit u_dwconv_unit (
    .clk_i(clk), .rst_ni(rst_ni), .clr_i(clr_i), .cmd_valid_i(cmd_valid_i),
    .cmd_i(cmd_i), .wr_en_i(wr_en_i), .data_i(data_i), .filt_i(filt_i),
    .done_o(done_o), .illegal_o(illegal_o), .acc_o(acc_o), .dst_o(dst_o));

  function automatic int phys(int i);
    int g = i / 8;
    int gm = (g == 1) ? 2 : (g == 2) ? 1 : g;
    return (i % 8) * 4 + gm;
  endfunction

  always_comb begin
    data_i = '0;
    filt_i = '0;
    for (int r = 0; r < 9; r++)
      for (int i = 0; i < NL; i++) data_i[(r*256 + phys(i)*8) +: 8] = dat[r][i];
    for (int r = 0; r < 3; r++)
      for (int i = 0; i < NL; i++) filt_i[(r*256 + phys(i)*8) +: 8] = fil[r][i];
  end

  function automatic void pick(int b, output int p, output int c, output int n);
    if (b <= 6) begin p = b; c = b + 1; n = b + 2; end
    else case (b)
      7: begin p = 1; c = 0; n = 2; end
      8: begin p = 1; c = 2; n = 0; end
      9: begin p = 3; c = 4; n = 0; end
      10: begin p = 5; c = 6; n = 0; end
      11: begin p = 7; c = 8; n = 0; end
      12: begin p = 2; c = 0; n = 1; end
      13: begin p = 4; c = 0; n = 1; end
      14: begin p = 6; c = 0; n = 1; end
      default: begin p = 8; c = 0; n = 1; end
    endcase
  endfunction

  function automatic int ext(logic [7:0] v, bit s);
    return s ? int'($signed(v)) : int'({24'd0, v});
  endfunction

  function automatic logic [31:0] lane_sum(int i, logic [31:0] c);
    int p, cu, n, mode, j, q, src, ln, tot;
    pick(int'(c[5:2]), p, cu, n);
    mode = int'(c[1:0]);
    j = i / 8;
    tot = 0;
    for (int k = 0; k < 3; k++) begin
      if (mode == 0) begin
        src = (k == 0) ? p : (k == 1) ? cu : n; ln = i;
      end else if (mode == 1) begin
        q = i % 8 + k - 1;
        if (q < 0) begin src = p; ln = 8*j + 7; end
        else if (q > 7) begin src = n; ln = 8*j; end
        else begin src = cu; ln = 8*j + q; end
      end else begin
        q = i % 8 + k;
        if (q > 7) begin src = cu; ln = 8*j + q - 8; end
        else begin src = p; ln = 8*j + q; end
      end
      tot += (ext(dat[src][ln], c[6]) + int'($signed(c[14:7]))) *
             (ext(fil[k][i], c[15]) + int'($signed(c[23:16])));
    end
    return tot;
  endfunction

  // reference model
  always @(posedge clk) begin
    m_tag = cur_tag;
    if (!rst_ni) begin
      for (int i = 0; i < NL; i++) begin macc[i] = 0; mdst[i] = 0; end
      mdone = 0; mill = 0;
    end else begin
      bit go, bad;
      go  = cmd_valid_i && cmd_i[1:0] != 2'd3;
      bad = cmd_valid_i && cmd_i[1:0] == 2'd3;
      for (int i = 0; i < NL; i++) begin
        logic [31:0] s;
        s = go ? lane_sum(i, cmd_i) : 32'd0;
        if (clr_i) macc[i] = go ? s : 32'd0;
        else if (go) macc[i] = macc[i] + s;
        if (go && wr_en_i) mdst[i] = macc[i];
      end
      mdone = go; mill = bad;
    end
  end

  task automatic check_bit(string what, logic act, logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0b expected=%0b", m_tag, what, act, exp);
    end
  endtask

  task automatic check_vec(string what, logic [NL*32-1:0] act, logic [31:0] exp [NL]);
    int bad = -1;
    compared++;
    for (int i = 0; i < NL; i++)
      if (bad < 0 && act[i*32 +: 32] !== exp[i]) bad = i;
    if (bad >= 0) begin
      mismatched++;
      $display("FAIL %s %s lane %0d actual=%h expected=%h", m_tag, what, bad,
               act[bad*32 +: 32], exp[bad]);
    end
  endtask

  always @(negedge clk) begin
    if (running) begin
      check_bit("done_o", done_o, mdone);
      check_bit("illegal_o", illegal_o, mill);
      check_vec("acc_o", acc_o, macc);
      check_vec("dst_o", dst_o, mdst);
    end
  end

  task automatic sync();
    @(posedge clk); #1;
  endtask

  task automatic drive(logic [31:0] c, bit wr, bit clr, string tag);
    cmd_valid_i = 1'b1; cmd_i = c; wr_en_i = wr; clr_i = clr; cur_tag = tag;
  endtask

  task automatic idle(string tag);
    cmd_valid_i = 1'b0; clr_i = 1'b0; wr_en_i = 1'b0; cur_tag = tag;
    cmd_i = $urandom;
  endtask

  task automatic rand_data();
    for (int r = 0; r < 9; r++) for (int i = 0; i < NL; i++) dat[r][i] = 8'($urandom);
    for (int r = 0; r < 3; r++) for (int i = 0; i < NL; i++) fil[r][i] = 8'($urandom);
  endtask

  function automatic logic [31:0] mk(int sp, int base, bit ds, int db, bit fs, int fb);
    return {8'h00, 8'(fb), fs, 8'(db), ds, 4'(base), 2'(sp)};
  endfunction

  task automatic sweep(int sp, int lo, int hi, string tag);
    for (int b = lo; b <= hi; b++) begin
      sync(); rand_data();
      drive(mk(sp, b, 1'($urandom), $urandom, 1'($urandom), $urandom), 1'b1, 1'b1, tag);
    end
    sync(); idle(tag);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (120000) @(posedge clk);
    compared++; mismatched++;
    $display("FAIL R12 watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    for (int r = 0; r < 9; r++) for (int i = 0; i < NL; i++) dat[r][i] = 0;
    for (int r = 0; r < 3; r++) for (int i = 0; i < NL; i++) fil[r][i] = 0;
    // R1: reset state
    @(posedge clk); running = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_ni = 1'b1;
    sync(); idle("R1");
    repeat (3) sync();

    // R2: ascending lanes through prev vector with unit filter tap 0
    sync();
    for (int i = 0; i < NL; i++) begin dat[0][i] = 8'(i + 1); fil[0][i] = 8'd1; end
    drive(mk(0, 0, 0, 0, 0, 0), 1'b1, 1'b1, "R2");
    sync(); idle("R2");
    sync();
    for (int i = 0; i < NL; i++) begin dat[1][i] = 8'(3*i); fil[1][i] = 8'd2; end
    drive(mk(0, 0, 0, 0, 0, 0), 1'b1, 1'b1, "R2");
    sync(); idle("R2");

    sweep(0, 0, 6, "R4");
    sweep(0, 7, 15, "R5");
    sweep(0, 0, 15, "R6");
    sweep(1, 0, 15, "R7");
    sweep(2, 0, 15, "R8");

    // R9: illegal mode after building state
    sync(); rand_data(); drive(mk(1, 3, 1, 5, 0, 9), 1'b1, 1'b0, "R9");
    for (int n = 0; n < 6; n++) begin
      sync(); rand_data();
      drive(mk(3, n, 1, $urandom, 1, $urandom) | {8'($urandom), 24'd0}, 1'b1, 1'b0, "R9");
    end
    sync(); drive(mk(3, 0, 0, 0, 0, 0), 1'b1, 1'b1, "R9");
    sync(); idle("R9");

    // R10: write-out disabled then enabled
    for (int n = 0; n < 4; n++) begin
      sync(); rand_data(); drive(mk(n % 3, n, 0, 3, 1, 250), 1'b0, 1'b0, "R10");
    end
    sync(); drive(mk(0, 4, 1, 0, 0, 0), 1'b1, 1'b0, "R10");
    sync(); idle("R10");

    // R11: accumulate, then clear coinciding with a command, then clear alone
    for (int n = 0; n < 5; n++) begin
      sync(); rand_data(); drive(mk(n % 3, n + 2, 1, 7, 1, 200), 1'b1, 1'b0, "R11");
    end
    sync(); rand_data(); drive(mk(1, 9, 0, 1, 1, 2), 1'b1, 1'b1, "R11");
    sync(); rand_data(); drive(mk(2, 5, 1, 0, 0, 0), 1'b0, 1'b0, "R11");
    sync(); rand_data(); drive(mk(0, 1, 0, 0, 0, 0), 1'b0, 1'b1, "R11");
    sync(); idle("R11"); clr_i = 1'b1;
    sync(); idle("R11");

    // R12: back-to-back commands with gaps
    for (int n = 0; n < 12; n++) begin
      sync();
      if (n % 4 == 3) idle("R12");
      else drive(mk(n % 3, n, 1, n, 0, n), 1'b1, 1'b0, "R12");
    end
    sync(); idle("R12");

    // R13: upper command bits toggled
    for (int n = 0; n < 8; n++) begin
      sync(); rand_data();
      drive(mk(n % 3, 15 - n, 1, 100, 1, 156) | {8'($urandom), 24'd0}, 1'b1, 1'b0, "R13");
    end
    sync(); idle("R13");

    // R3: random mixtures of signedness, biases, modes, clears
    for (int n = 0; n < 1500; n++) begin
      sync();
      if (n % 3 == 0) rand_data();
      if ($urandom % 5 == 0) begin idle("R3"); clr_i = 1'($urandom % 4 == 0); end
      else drive($urandom, 1'($urandom), 1'($urandom % 8 == 0), "R3");
    end
    sync(); idle("R3");
    repeat (3) sync();
    summary();
  end

endmodule